// File: doc/BRIEF.md
# Received Frame Length and FCS Checker

This block sits behind a receive deframer. The deframer has already removed the flags and the stuffing. The block takes a byte stream marked with frame start, frame end and abort markers. It counts the bytes of each frame and checks the count against a programmable minimum and maximum. It also verifies a frame check sequence, either 16-bit or 32-bit, with the width chosen at run time. The block can drop a fixed-size line header at the front of every frame. It can also hold back the trailing check bytes so that they are not forwarded.

The forwarded byte stream marks the first byte of each frame. Every frame closes with a separate end beat that carries an error flag: the flag is raised for a length violation, a check failure, an abort, or a frame cut short by a new start marker. Three saturating counters record the frame outcomes: good frames, length violations and check failures. A read strobe copies all three counters into output registers and restarts the counts from zero.

Top module: `rx_frame_check`

## Requirements
- R1: A byte is accepted only inside a frame, which opens with a start-marked beat. Beats outside a frame produce no forwarded byte and no end beat.
- R2: The frame length counts the bytes after the header and includes the check bytes. A frame that ends with fewer than `cfg_min_len` bytes closes with the error flag set and adds one to the length-violation counter.
- R3: When byte number `cfg_max_len`+1 arrives, the frame closes at once with the error flag set and adds one to the length-violation counter. That byte and every later byte are discarded up to the next start marker, and no second end beat is produced.
- R4: With `cfg_fcs32`=0 the check is a 16-bit CRC. It is processed least significant bit first, with reflected polynomial 0x8408 and an all-ones preset. The sender appends the complemented CRC, low byte first. A frame is good when the running value over all counted bytes equals 0xF0B8.
- R5: With `cfg_fcs32`=1 the check is a 32-bit CRC. It uses reflected polynomial 0xEDB88320, an all-ones preset and complemented, low-byte-first check bytes. A frame is good when the residue equals 0xDEBB20E3.
- R6: For a frame whose length is within limits, a failed check closes the frame with the error flag set and adds one to the check-error counter. A passed check closes it with the flag clear and adds one to the good counter. A length violation takes precedence, and the check result is then not counted.
- R7: With `cfg_strip_fcs`=0 every counted byte is forwarded one clock edge after it is sampled. With `cfg_strip_fcs`=1 the last 2 bytes (16-bit check) or the last 4 bytes (32-bit check) are never forwarded. Each other byte appears one edge after the byte 2 or 4 positions later is sampled.
- R8: With `cfg_hdr_strip`=1 the first 4 bytes of each frame are neither forwarded nor counted, and they are not included in the check.
- R9: The end beat (`out_fin`) is registered and appears one edge after the final byte is sampled. `out_sof` marks the first forwarded byte of a frame.
- R10: An abort-marked beat inside a frame closes the frame with the error flag set and changes no counter. The following bytes are discarded up to the next start marker.
- R11: A start marker while a frame is open closes the old frame with the error flag set and changes no counter. The new frame begins with that byte. If that beat also carries an end marker, the beat is dropped.
- R12: At the edge that samples `stat_rd`, the three outputs take the current counts and the counters restart. An event at that same edge counts toward the new period. Between reads the outputs hold, and the counters saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_fcs32 | input | 1 | 1 selects the 32-bit check, 0 the 16-bit check |
| cfg_strip_fcs | input | 1 | Withhold the check bytes from the output |
| cfg_hdr_strip | input | 1 | Drop the 4-byte line header |
| cfg_min_len | input | LEN_W | Minimum frame length in bytes |
| cfg_max_len | input | LEN_W | Maximum frame length in bytes (at least 1) |
| in_valid | input | 1 | Input beat present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_abort | input | 1 | Beat is an abort marker; its data is ignored |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | First forwarded byte of a frame |
| out_fin | output | 1 | Frame end beat |
| out_err | output | 1 | Error flag of the end beat |
| stat_rd | input | 1 | Read strobe for the counters |
| stat_good | output | CNT_W | Good-frame count at the last read |
| stat_size | output | CNT_W | Length-violation count at the last read |
| stat_fcs | output | CNT_W | Check-error count at the last read |

## Verification
The end beat is due one edge after the byte that closes the frame is sampled: the end-marked byte, the overflowing byte, the abort beat or the new start byte. A forwarded byte is due one edge after its own arrival, or, with stripping enabled, one edge after the byte 2 or 4 places behind it arrives. The counter outputs change one edge after `stat_rd`. The bench drives and samples on falling edges and stamps every beat with a cycle number. It then compares the stamps of the first forwarded byte and of the end beat with the cycle numbers derived from these rules.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

   localparam logic [15:0] POLY16 = 16'h8408;
   localparam logic [15:0] RES16  = 16'hF0B8;
   localparam logic [31:0] POLY32 = 32'hEDB88320;
   localparam logic [31:0] RES32  = 32'hDEBB20E3;

   typedef enum logic [1:0] {
      EV_GOOD = 2'd0,
      EV_SIZE = 2'd1,
      EV_FCS  = 2'd2
   } ev_idx_e;

   localparam int NUM_EV = 3;

   function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c ^ {8'h00, d};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ POLY16) : (r >> 1);
      end
      return r;
   endfunction

   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'h0, d};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ POLY32) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/rxfc_crc.sv
module rxfc_crc #(
   parameter int W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init,
   input  logic       en,
   input  logic [7:0] d,
   output logic       ok
);
   logic [W-1:0] st_q;
   logic [W-1:0] base;
   logic [W-1:0] nxt;
   logic [W-1:0] after;
   logic [W-1:0] res;

   assign base = init ? {W{1'b1}} : st_q;

   generate
      if (W == 16) begin : g_w16
         always_comb nxt = rxfc_pkg::crc16_step(base, d);
         assign res = rxfc_pkg::RES16;
      end else if (W == 32) begin : g_w32
         always_comb nxt = rxfc_pkg::crc32_step(base, d);
         assign res = rxfc_pkg::RES32;
      end else begin : g_bad
         $error("rxfc_crc: W must be 16 or 32");
      end
   endgenerate

   assign after = en ? nxt : base;
   assign ok    = (after == res);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= {W{1'b1}};
      else        st_q <= after;
   end
endmodule

// File: rtl/rxfc_ctrl.sv
module rxfc_ctrl #(
   parameter int LEN_W     = 16,
   parameter int HDR_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_fcs32,
   input  logic             cfg_hdr_strip,
   input  logic [LEN_W-1:0] cfg_min_len,
   input  logic [LEN_W-1:0] cfg_max_len,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic             in_abort,
   input  logic             crc16_ok,
   input  logic             crc32_ok,
   output logic             start,
   output logic             push,
   output logic             close,
   output logic             fin,
   output logic             fin_err,
   output logic [rxfc_pkg::NUM_EV-1:0] ev
);
   localparam int HW = $clog2(HDR_BYTES + 1);

   logic             open_q;
   logic [HW-1:0]    hdr_q;
   logic [LEN_W-1:0] len_q;

   logic             abt, restart, drop_beat, live, hdr_byte, pay, ovf, endf, runt, fcs_ok;
   logic [HW-1:0]    h_base;
   logic [LEN_W-1:0] l_base;
   logic [LEN_W:0]   newlen, flen;

   always_comb begin
      abt       = in_valid & in_abort & open_q;
      start     = in_valid & ~in_abort & in_sof;
      restart   = start & open_q;
      drop_beat = restart & in_eof;
      live      = in_valid & ~in_abort & (start | open_q) & ~drop_beat;
      h_base    = start ? '0 : hdr_q;
      l_base    = start ? '0 : len_q;
      hdr_byte  = cfg_hdr_strip & (h_base < HW'(HDR_BYTES));
      pay       = live & ~hdr_byte;
      newlen    = {1'b0, l_base} + 1'b1;
      ovf       = pay & (newlen > {1'b0, cfg_max_len});
      push      = pay & ~ovf;
      endf      = live & in_eof & ~ovf;
      flen      = pay ? newlen : {1'b0, l_base};
      runt      = flen < {1'b0, cfg_min_len};
      fcs_ok    = cfg_fcs32 ? crc32_ok : crc16_ok;
      close     = abt | ovf | endf;
      fin       = abt | restart | ovf | endf;
      fin_err   = abt | restart | ovf | (endf & (runt | ~fcs_ok));
      ev[rxfc_pkg::EV_SIZE] = ovf | (endf & runt);
      ev[rxfc_pkg::EV_FCS]  = endf & ~runt & ~fcs_ok;
      ev[rxfc_pkg::EV_GOOD] = endf & ~runt & fcs_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         hdr_q  <= '0;
         len_q  <= '0;
      end else begin
         if (abt)        open_q <= 1'b0;
         else if (start) open_q <= ~drop_beat & ~ovf & ~endf;
         else if (open_q) open_q <= ~ovf & ~endf;
         if (live) begin
            hdr_q <= hdr_byte ? h_base + 1'b1 : h_base;
            len_q <= push ? newlen[LEN_W-1:0] : l_base;
         end
      end
   end
endmodule

// File: rtl/rxfc_dly.sv
module rxfc_dly #(
   parameter int DEPTH = 4,
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] dep,
   input  logic             flush_pre,
   input  logic             flush_post,
   input  logic             push,
   input  logic [7:0]       din,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             out_sof
);
   logic [7:0]       buf_q [DEPTH];
   logic [7:0]       nbuf  [DEPTH];
   logic [OCC_W-1:0] occ_q, occ_b, nocc;
   logic             first_q, first_b, emit;
   logic [7:0]       edat;

   always_comb begin
      occ_b   = flush_pre ? '0 : occ_q;
      first_b = flush_pre | first_q;
      emit    = 1'b0;
      edat    = buf_q[0];
      nbuf    = buf_q;
      nocc    = occ_b;
      if (push) begin
         if (occ_b == dep) begin
            emit = 1'b1;
            if (dep == '0) begin
               edat = din;
            end else begin
               for (int i = 0; i < DEPTH - 1; i++) nbuf[i] = buf_q[i + 1];
               for (int i = 0; i < DEPTH; i++) begin
                  if (i == int'(dep) - 1) nbuf[i] = din;
               end
            end
         end else begin
            for (int i = 0; i < DEPTH; i++) begin
               if (i == int'(occ_b)) nbuf[i] = din;
            end
            nocc = occ_b + 1'b1;
         end
      end
      if (flush_post) nocc = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q     <= '0;
         first_q   <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sof   <= 1'b0;
         for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
      end else begin
         occ_q     <= nocc;
         first_q   <= first_b & ~emit;
         out_valid <= emit;
         out_data  <= edat;
         out_sof   <= emit & first_b;
         buf_q     <= nbuf;
      end
   end
endmodule

// File: rtl/rxfc_stats.sv
module rxfc_stats #(
   parameter int CNT_W = 16,
   parameter int N     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     ev,
   input  logic             rd,
   output logic [CNT_W-1:0] snap [N]
);
   logic [CNT_W-1:0] live_q [N];

   for (genvar g = 0; g < N; g++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            live_q[g] <= '0;
            snap[g]   <= '0;
         end else if (rd) begin
            snap[g]   <= live_q[g];
            live_q[g] <= ev[g] ? CNT_W'(1) : '0;
         end else if (ev[g] && live_q[g] != {CNT_W{1'b1}}) begin
            live_q[g] <= live_q[g] + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rx_frame_check.sv
module rx_frame_check #(
   parameter int LEN_W     = 16,
   parameter int CNT_W     = 16,
   parameter int HDR_BYTES = 4,
   parameter int FCS_MAX   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_fcs32,
   input  logic             cfg_strip_fcs,
   input  logic             cfg_hdr_strip,
   input  logic [LEN_W-1:0] cfg_min_len,
   input  logic [LEN_W-1:0] cfg_max_len,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic             in_abort,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             out_sof,
   output logic             out_fin,
   output logic             out_err,
   input  logic             stat_rd,
   output logic [CNT_W-1:0] stat_good,
   output logic [CNT_W-1:0] stat_size,
   output logic [CNT_W-1:0] stat_fcs
);
   localparam int OCC_W = $clog2(FCS_MAX + 1);

   generate
      if (FCS_MAX < 4) begin : g_chk_fcs
         $error("rx_frame_check: FCS_MAX must cover a 4-byte check");
      end
      if (LEN_W < 4 || CNT_W < 2 || HDR_BYTES < 1) begin : g_chk_w
         $error("rx_frame_check: width parameters out of range");
      end
   endgenerate

   logic start, push, close, fin, fin_err;
   logic crc16_ok, crc32_ok;
   logic [rxfc_pkg::NUM_EV-1:0] ev;
   logic [CNT_W-1:0] snap [rxfc_pkg::NUM_EV];
   logic [OCC_W-1:0] dep;

   assign dep = cfg_strip_fcs ? (cfg_fcs32 ? OCC_W'(4) : OCC_W'(2)) : '0;

   rxfc_ctrl #(.LEN_W(LEN_W), .HDR_BYTES(HDR_BYTES)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_fcs32(cfg_fcs32), .cfg_hdr_strip(cfg_hdr_strip),
      .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_abort(in_abort),
      .crc16_ok(crc16_ok), .crc32_ok(crc32_ok),
      .start(start), .push(push), .close(close), .fin(fin), .fin_err(fin_err), .ev(ev)
   );

   rxfc_crc #(.W(16)) u_crc16 (
      .clk(clk), .rst_n(rst_n), .init(start), .en(push), .d(in_data), .ok(crc16_ok)
   );

   rxfc_crc #(.W(32)) u_crc32 (
      .clk(clk), .rst_n(rst_n), .init(start), .en(push), .d(in_data), .ok(crc32_ok)
   );

   rxfc_dly #(.DEPTH(FCS_MAX)) u_dly (
      .clk(clk), .rst_n(rst_n), .dep(dep),
      .flush_pre(start), .flush_post(close), .push(push), .din(in_data),
      .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof)
   );

   rxfc_stats #(.CNT_W(CNT_W), .N(rxfc_pkg::NUM_EV)) u_stats (
      .clk(clk), .rst_n(rst_n), .ev(ev), .rd(stat_rd), .snap(snap)
   );

   assign stat_good = snap[rxfc_pkg::EV_GOOD];
   assign stat_size = snap[rxfc_pkg::EV_SIZE];
   assign stat_fcs  = snap[rxfc_pkg::EV_FCS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_fin <= 1'b0;
         out_err <= 1'b0;
      end else begin
         out_fin <= fin;
         out_err <= fin & fin_err;
      end
   end
endmodule

// File: rtl/rx_frame_check_chk.sv
module rx_frame_check_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_abort,
   input logic             out_valid,
   input logic             out_sof,
   input logic             out_fin,
   input logic             out_err,
   input logic             stat_rd,
   input logic [CNT_W-1:0] stat_good,
   input logic [CNT_W-1:0] stat_size,
   input logic [CNT_W-1:0] stat_fcs
);
   AST_ERR_NEEDS_FIN: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_fin); // R9
   AST_SOF_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid); // R9
   AST_FIN_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      out_fin |-> $past(in_valid)); // R9
   AST_IDLE_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R1
   AST_ABORT_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_abort) |=> !out_valid); // R10
   AST_GOOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd |=> $stable(stat_good)); // R12
   AST_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd |=> $stable(stat_size)); // R12
   AST_FCS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd |=> $stable(stat_fcs)); // R12
endmodule

bind rx_frame_check rx_frame_check_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_abort(in_abort),
   .out_valid(out_valid), .out_sof(out_sof), .out_fin(out_fin), .out_err(out_err),
   .stat_rd(stat_rd), .stat_good(stat_good), .stat_size(stat_size), .stat_fcs(stat_fcs)
);

// File: tb/rx_frame_check_tb.sv
module rx_frame_check_tb;
   localparam int LW = 16;
   localparam int CW = 16;
   localparam int MINL = 6;
   localparam int MAXL = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_fcs32 = 0, cfg_strip_fcs = 0, cfg_hdr_strip = 0;
   logic [LW-1:0] cfg_min_len = LW'(MINL), cfg_max_len = LW'(MAXL);
   logic in_valid = 0, in_sof = 0, in_eof = 0, in_abort = 0;
   logic [7:0] in_data = 0;
   logic out_valid, out_sof, out_fin, out_err;
   logic [7:0] out_data;
   logic stat_rd = 0;
   logic [CW-1:0] stat_good, stat_size, stat_fcs;

   rx_frame_check #(.LEN_W(LW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_fcs32(cfg_fcs32), .cfg_strip_fcs(cfg_strip_fcs),
      .cfg_hdr_strip(cfg_hdr_strip), .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len),
      .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
      .in_abort(in_abort), .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
      .out_fin(out_fin), .out_err(out_err), .stat_rd(stat_rd), .stat_good(stat_good),
      .stat_size(stat_size), .stat_fcs(stat_fcs)
   );

   always #5 clk = ~clk;

   int n_run = 0, n_fail = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   initial begin
      repeat (150000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   // capture
   logic [7:0] cap [0:255];
   int cap_n, sof_n, sof_pos, fin_n, first_cyc, fin_cyc;
   bit fin_err_last, fin_err_first;
   always @(negedge clk) begin
      if (out_valid) begin
         if (cap_n == 0) first_cyc = cyc;
         if (out_sof) begin sof_n++; sof_pos = cap_n; end
         if (cap_n < 256) cap[cap_n] = out_data;
         cap_n++;
      end
      if (out_fin) begin
         if (fin_n == 0) fin_err_first = out_err;
         fin_err_last = out_err;
         fin_n++;
         fin_cyc = cyc;
      end
   end

   // stimulus buffers
   logic [7:0] tx_d [0:63];
   bit tx_s [0:63], tx_e [0:63], tx_a [0:63];
   int dcyc [0:63];
   int tx_n;
   logic [7:0] pl [0:63];
   int g_r, s_r, f_r;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_cap();
      @(posedge clk);
      cap_n = 0; sof_n = 0; sof_pos = -1; fin_n = 0; first_cyc = -1; fin_cyc = -1;
      fin_err_last = 0; fin_err_first = 0; tx_n = 0;
   endtask

   task automatic drive();
      for (int i = 0; i < tx_n; i++) begin
         @(negedge clk);
         in_valid = 1; in_data = tx_d[i]; in_sof = tx_s[i]; in_eof = tx_e[i]; in_abort = tx_a[i];
         dcyc[i] = cyc;
      end
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0; in_abort = 0;
      repeat (8) @(negedge clk);
   endtask

   task automatic read_stats();
      @(negedge clk); stat_rd = 1;
      @(negedge clk); stat_rd = 0;
      g_r = int'(stat_good); s_r = int'(stat_size); f_r = int'(stat_fcs);
   endtask

   task automatic put(input logic [7:0] d, input bit s, input bit e, input bit a);
      tx_d[tx_n] = d; tx_s[tx_n] = s; tx_e[tx_n] = e; tx_a[tx_n] = a; tx_n++;
   endtask

   // serial CRC over pl[0..n-1], feedback taken per bit
   function automatic logic [31:0] bench_fcs(input int n, input bit wide);
      logic [31:0] c;
      bit fb;
      c = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
      for (int i = 0; i < n; i++) begin
         for (int k = 0; k < 8; k++) begin
            fb = c[0] ^ pl[i][k];
            c = c >> 1;
            if (fb) c = c ^ (wide ? 32'hEDB88320 : 32'h00008408);
         end
      end
      return wide ? ~c : {16'h0, ~c[15:0]};
   endfunction

   // builds payload of L counted bytes into pl and appends frame beats to tx
   task automatic make_frame(input int L, input bit wide, input bit bad, input bit hd, input int seed);
      int fw, nd;
      logic [31:0] f;
      fw = wide ? 4 : 2;
      if (L >= fw) begin
         nd = L - fw;
         for (int i = 0; i < nd; i++) pl[i] = 8'((i * 37 + L * 11 + seed * 5 + 3) & 255);
         f = bench_fcs(nd, wide);
         for (int j = 0; j < fw; j++) pl[nd + j] = f[8*j +: 8];
         if (bad) pl[L - 1] = pl[L - 1] ^ 8'h01;
      end else begin
         for (int i = 0; i < L; i++) pl[i] = 8'(i * 13 + 7);
      end
      if (hd) for (int i = 0; i < 4; i++) put(8'(8'hA0 + i), i == 0, 0, 0);
      for (int i = 0; i < L; i++) put(pl[i], !hd && i == 0, i == L - 1, 0);
   endtask

   initial begin
      int hoff, D, fwd, exp_err, eg, es, ef, mism, fin_at;
      string tg;
      repeat (3) @(negedge clk);
      // reset state
      chk("R9", "reset out_valid", int'(out_valid), 0);
      chk("R9", "reset out_fin", int'(out_fin), 0);
      chk("R12", "reset stat_good", int'(stat_good), 0);
      rst_n = 1;

      // R1: bytes with no start marker
      clear_cap();
      for (int i = 0; i < 5; i++) put(8'(i + 1), 0, i == 4, 0);
      drive();
      chk("R1", "bytes outside frame", cap_n, 0);
      chk("R1", "end beats outside frame", fin_n, 0);

      // near-exhaustive sweep
      for (int fs = 0; fs < 2; fs++)
      for (int st = 0; st < 2; st++)
      for (int hd = 0; hd < 2; hd++)
      for (int L = 1; L <= 14; L++)
      for (int bad = 0; bad < 2; bad++) begin
         cfg_fcs32 = fs[0]; cfg_strip_fcs = st[0]; cfg_hdr_strip = hd[0];
         clear_cap();
         make_frame(L, fs[0], bad[0], hd[0], fs * 3 + st + hd);
         drive();
         hoff = hd ? 4 : 0;
         D = st ? (fs ? 4 : 2) : 0;
         eg = 0; es = 0; ef = 0;
         if (L > MAXL) begin
            exp_err = 1; es = 1; fwd = MAXL - D; fin_at = hoff + MAXL; tg = "R3";
         end else if (L < MINL) begin
            exp_err = 1; es = 1; fwd = (L > D) ? L - D : 0; fin_at = hoff + L - 1; tg = "R2";
         end else begin
            exp_err = bad; eg = !bad; ef = bad; fwd = L - D; fin_at = hoff + L - 1;
            tg = fs ? "R5" : "R4";
         end
         mism = 0;
         for (int i = 0; i < fwd && i < cap_n; i++) if (cap[i] !== pl[i]) mism++;
         chk(st ? "R7" : "R8", "forwarded count", cap_n, fwd);
         chk(hd ? "R8" : "R7", "forwarded byte mismatches", mism, 0);
         chk("R9", "end beats", fin_n, 1);
         chk(tg, "end error flag", int'(fin_err_last), exp_err);
         chk("R9", "end beat cycle", fin_cyc, dcyc[fin_at] + 1);
         if (fwd > 0) begin
            chk("R7", "first byte cycle", first_cyc, dcyc[hoff + D] + 1);
            chk("R9", "sof position", sof_pos, 0);
         end
         chk("R9", "sof count", sof_n, fwd > 0 ? 1 : 0);
         read_stats();
         chk("R6", "good count", g_r, eg);
         chk(tg, "size count", s_r, es);
         chk("R6", "fcs count", f_r, ef);
      end

      // R10: abort mid-frame
      cfg_fcs32 = 0; cfg_strip_fcs = 0; cfg_hdr_strip = 0;
      clear_cap();
      for (int i = 0; i < 3; i++) put(8'(i + 9), i == 0, 0, 0);
      put(8'h00, 0, 0, 1);
      put(8'h55, 0, 0, 0); put(8'h66, 0, 1, 0);
      drive();
      chk("R10", "bytes before abort", cap_n, 3);
      chk("R10", "end beats", fin_n, 1);
      chk("R10", "error flag", int'(fin_err_last), 1);
      read_stats();
      chk("R10", "counters untouched", g_r + s_r + f_r, 0);

      // R11: start marker while open
      clear_cap();
      for (int i = 0; i < 3; i++) put(8'(i + 20), i == 0, 0, 0);
      make_frame(8, 0, 0, 0, 7);
      drive();
      chk("R11", "end beats", fin_n, 2);
      chk("R11", "old frame error", int'(fin_err_first), 1);
      chk("R11", "new frame error", int'(fin_err_last), 0);
      chk("R11", "bytes forwarded", cap_n, 11);
      chk("R11", "sof count", sof_n, 2);
      read_stats();
      chk("R11", "good count", g_r, 1);
      chk("R11", "size+fcs counts", s_r + f_r, 0);

      // R11: start+end beat while open is dropped
      clear_cap();
      put(8'h31, 1, 0, 0); put(8'h32, 0, 0, 0); put(8'h33, 1, 1, 0);
      drive();
      chk("R11", "dropped beat bytes", cap_n, 2);
      chk("R11", "dropped beat ends", fin_n, 1);

      // R12: accumulation then clear
      clear_cap();
      make_frame(8, 1, 0, 0, 1);
      make_frame(9, 1, 0, 0, 2);
      make_frame(7, 1, 1, 0, 3);
      cfg_fcs32 = 1;
      drive();
      read_stats();
      chk("R12", "accumulated good", g_r, 2);
      chk("R12", "accumulated fcs", f_r, 1);
      read_stats();
      chk("R12", "cleared good", g_r, 0);
      chk("R12", "cleared fcs", f_r, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule